// File: doc/BRIEF.md
# AXI4-Stream Counting Burst Source

This block emits one bounded burst of incrementing 32-bit count words on an AXI4-Stream master port. It is meant to feed the stream-to-memory write channel of a DMA engine during bring-up and test. Software arms a transfer by setting a length limit and raising a start signal, typically from general-purpose output bits. Software then polls a busy flag or waits for a done pulse.

The sink may hold tready high from reset onward, so the sink cannot hold data back before a transfer is set up. For that reason the block offers nothing until it detects a rising edge on start. Each rising edge produces exactly one packet. The words run 0, 1, ... up to the limit, and the limit word carries tlast. After the tlast beat is accepted, the block returns to idle and waits for the next rising edge.

Top module: `axis_count_burst`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, tvalid_o, tlast_o, busy_o and done_o are all low.
- R2: tvalid_o stays low while no rising edge of start_i has been sampled, even when tready_i is held high.
- R3: start_i is sampled on each rising clock edge. If it is high at an edge where it was low at the previous edge, and the block is idle, tvalid_o is high after that same edge, with tdata_o = 0.
- R4: The count on tdata_o advances by one only after an edge at which tvalid_o and tready_i were both high. While tvalid_o is high and tready_i is low, tdata_o, tvalid_o and tlast_o hold their values.
- R5: The packet carries limit+1 beats, with tdata_o taking the values 0 to limit. tlast_o is high on exactly the beat whose tdata_o equals the limit.
- R6: A limit of 0 gives a single-beat packet, with tdata_o = 0 and tlast_o high on that beat.
- R7: After the tlast beat is accepted, tvalid_o is low. A start_i level that stays high across the end of the packet launches no new packet. A new packet needs start_i to go low and then rise again.
- R8: busy_o is high from the cycle the first beat is offered through the cycle the tlast beat is accepted. done_o is high for exactly the one cycle after that acceptance.
- R9: The limit is captured when the packet launches, so later changes to limit_i do not affect the packet in flight. A rising edge of start_i while a packet is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request; acts on its rising edge |
| limit_i | input | 16 | Value of the last word; the packet carries limit+1 beats |
| tdata_o | output | 32 | Stream data: the current count |
| tvalid_o | output | 1 | Stream valid |
| tready_i | input | 1 | Stream ready from the sink |
| tlast_o | output | 1 | Marks the final beat |
| busy_o | output | 1 | Packet in flight |
| done_o | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The hardest case to reach from the ports is one where start and backpressure interact with the end of a packet. In that case start_i is still high, or rises a second time, while the tlast beat is stalled by tready_i low. The bench covers it with a phase that holds start_i high through a whole packet. A second phase pulses start_i mid-packet during a random tready_i pattern. It also changes limit_i mid-packet. A behavioural model runs cycle by cycle and shows that no second packet and no length change appear.

// File: rtl/pktgen_pkg.sv
package pktgen_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } pktgen_state_e;
endpackage

// File: rtl/pktgen_start_detect.sv
module pktgen_start_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rise_o
);
  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  assign rise_o = start_i & ~start_q;
endmodule

// File: rtl/pktgen_beat_engine.sv
module pktgen_beat_engine
  import pktgen_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [LW-1:0] limit_i,
  input  logic          tready_i,
  output logic [DW-1:0] tdata_o,
  output logic          tvalid_o,
  output logic          tlast_o,
  output logic          launch_o,
  output logic          final_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  pktgen_state_e state_q;
  logic [DW-1:0] cnt_q;
  logic [LW-1:0] lim_q;
  logic          last_q;
  logic          fire;
  logic [DW-1:0] cnt_nxt;

  assign fire     = (state_q == ST_SEND) & tready_i;
  assign cnt_nxt  = cnt_q + ONE;
  assign launch_o = (state_q == ST_IDLE) & rise_i;
  assign final_o  = fire & last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise_i) begin
          state_q <= ST_SEND;
          cnt_q   <= '0;
          lim_q   <= limit_i;
          last_q  <= (limit_i == '0);
        end
        ST_SEND: if (fire) begin
          if (last_q) begin
            state_q <= ST_IDLE;
            last_q  <= 1'b0;
          end else begin
            cnt_q  <= cnt_nxt;
            last_q <= (cnt_nxt == DW'(lim_q));
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tdata_o  = cnt_q;
  assign tvalid_o = (state_q == ST_SEND);
  assign tlast_o  = last_q;

  // stall keeps the beat unchanged
  assert_hold_on_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tlast_o)));
  // accepted non-final beat steps the count by one
  assert_step_on_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && tready_i && !tlast_o) |=> (tvalid_o && tdata_o == $past(tdata_o) + ONE));
  // valid only ever rises from a detected start edge
  assert_valid_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tvalid_o) |-> ($past(rise_i) && tdata_o == '0));
  // last beat carries the captured limit
  assert_last_at_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && tlast_o) |-> (tdata_o == DW'(lim_q)));
  // final acceptance leaves the port idle
  assert_idle_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && tready_i && tlast_o) |=> !tvalid_o);
  assert_no_last_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tvalid_o |-> !tlast_o);
endmodule

// File: rtl/pktgen_status.sv
module pktgen_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic final_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_i;
      if (launch_i)     busy_q <= 1'b1;
      else if (final_i) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/axis_count_burst.sv
module axis_count_burst
  import pktgen_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] limit_i,
  output logic [DW-1:0] tdata_o,
  output logic          tvalid_o,
  input  logic          tready_i,
  output logic          tlast_o,
  output logic          busy_o,
  output logic          done_o
);
  logic rise, launch, fin;

  pktgen_start_detect u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .rise_o (rise)
  );

  pktgen_beat_engine #(.DW(DW), .LW(LW)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .limit_i (limit_i),
    .tready_i(tready_i),
    .tdata_o (tdata_o),
    .tvalid_o(tvalid_o),
    .tlast_o (tlast_o),
    .launch_o(launch),
    .final_o (fin)
  );

  pktgen_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .final_i (fin),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // busy tracks the offered stream
  assert_busy_matches_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == tvalid_o);
  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tvalid_o && tready_i && tlast_o));
endmodule

// File: tb/axis_count_burst_bench.sv
module axis_count_burst_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] limit = '0;
  logic        tready = 1'b0;
  logic [31:0] tdata;
  logic        tvalid, tlast, busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;
  string req = "R1";

  // reference model state
  bit m_valid, m_last, m_done, m_sq;
  int m_cnt, m_lim;

  always #(CLK_PERIOD/2) clk = ~clk;

  axis_count_burst u_axis_count_burst (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .limit_i(limit),
    .tdata_o(tdata), .tvalid_o(tvalid), .tready_i(tready), .tlast_o(tlast),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid = 0; m_last = 0; m_done = 0; m_sq = 0; m_cnt = 0; m_lim = 0;
    end else begin
      bit rise;
      rise = start && !m_sq;
      m_sq = start;
      m_done = 0;
      if (m_valid) begin
        if (tready) begin
          if (m_last) begin m_valid = 0; m_last = 0; m_done = 1; end
          else begin m_cnt++; m_last = (m_cnt == m_lim); end
        end
      end else if (rise) begin
        m_valid = 1; m_cnt = 0; m_lim = limit; m_last = (limit == 0);
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check("tvalid", tvalid, m_valid);
      check("busy", busy, m_valid);
      check("done", done, m_done);
      if (m_valid) begin
        check("tdata", tdata, m_cnt);
        check("tlast", tlast, m_last);
      end else check("tlast idle", tlast, 0);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start(logic [15:0] lim);
    limit = lim; start = 1'b1; step(1); start = 1'b0;
  endtask

  task automatic wait_idle(bit rnd);
    for (int i = 0; i < 2000; i++) begin
      if (rnd) tready = 1'($urandom_range(0, 1));
      step(1);
      if (!m_valid && !tvalid) break;
    end
    tready = 1'b1;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    req = "R1"; tready = 1'b1; step(3);
    rst_ni = 1'b1; step(1);
    req = "R2"; step(10);                      // sink ready, nothing armed
    req = "R3"; pulse_start(16'd3); step(1);
    req = "R5"; wait_idle(0); step(2);
    req = "R6"; pulse_start(16'd0); wait_idle(0); step(2);
    req = "R7"; limit = 16'd4; start = 1'b1; step(15); // held level: one packet only
    start = 1'b0; step(2);
    req = "R8"; pulse_start(16'd2); tready = 1'b0; step(3); tready = 1'b1; wait_idle(0); step(2);
    req = "R4"; pulse_start(16'd25); wait_idle(1); step(2);
    req = "R9"; pulse_start(16'd12); limit = 16'd2; step(2);
    start = 1'b1; step(1); start = 1'b0; wait_idle(1); step(3);
    req = "R7"; pulse_start(16'd5); tready = 1'b0; step(6);   // stall the beat
    req = "R1"; rst_ni = 1'b0; step(2); rst_ni = 1'b1; tready = 1'b1; step(4);
    summary();
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end
endmodule